// File: doc/BRIEF.md
# Indirect Four-Lane Vector Multiply-Accumulate Datapath

This block is a four-lane, 32-bit compute datapath. Its operands are not taken from packed vector registers. Each lane instead picks its two source elements and its destination element from a flat element file, using per-lane index sets supplied with the instruction. In one cycle the block gathers four elements through the first index set and four through the second. It applies a lane-wise move, add or multiply-accumulate, then scatters the four results to the locations named by the destination index set. No lane is tied to any particular alignment or slot, so broadcast operands, strided gathers and swapped pair orders all run at the full issue rate with no extra step.

A separate load port fills single elements of the file from the memory side. Each lane holds a 40-bit accumulator. A clear input resets the accumulators, and a clear that arrives together with a multiply-accumulate starts a fresh sum, which suits the first tap of a filter. Index generation happens upstream, so all indices arrive as plain inputs.

Top module: `vgather_mac_dp`

## Requirements
- R1: After reset every element of the file, every accumulator, `res_o` and `res_valid_o` are zero.
- R2: When `ld_en_i` is high at a clock edge, `ld_data_i` is stored at element `ld_idx_i` and can be gathered from the next cycle on.
- R3: Lane l takes its index from bits [7l+6:7l] of each index bus. An issued operation with op 00 (move) returns the element at the lane's A index on lane l of `res_o` (bits [32l+31:32l]) one cycle after issue, with `res_valid_o` high in that cycle, and writes the same value to the lane's destination index.
- R4: Op 01 (add) returns and writes the 32-bit wrapping sum of the lane's A and B elements.
- R5: Op 10 (multiply-accumulate) adds the signed product of the low 16 bits of the A and B elements, sign-extended, to the lane's 40-bit accumulator with wraparound. The result returned and written is the low 32 bits of the new accumulator. `acc_o` bits [40l+39:40l] show lane l's accumulator.
- R6: `acc_clr_i` without a multiply-accumulate zeroes all accumulators at the next edge. With a multiply-accumulate in the same cycle, each accumulator becomes that cycle's product.
- R7: Any index pattern (all lanes equal, stride 2, reversed pairs, arbitrary) is served in the cycle of issue, so back-to-back issues give `res_valid_o` high in every following cycle.
- R8: If several lanes name the same destination, the highest-numbered lane's value is stored. A scatter write takes priority over a load to the same index in the same cycle.
- R9: A gather of an element that is written in the same cycle returns the element's old value. The new value is visible from the next cycle.
- R10: When `issue_i` is low, or op is 11 (idle), nothing is written to the file, no accumulator changes unless `acc_clr_i` is high, and `res_valid_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation issue strobe |
| op_i | input | 2 | 00 move, 01 add, 10 multiply-accumulate, 11 idle |
| src_a_idx_i | input | 28 | Four 7-bit first-operand indices, lane 0 in the low bits |
| src_b_idx_i | input | 28 | Four 7-bit second-operand indices |
| dst_idx_i | input | 28 | Four 7-bit destination indices |
| acc_clr_i | input | 1 | Accumulator clear |
| ld_en_i | input | 1 | Single-element load strobe |
| ld_idx_i | input | 7 | Load index |
| ld_data_i | input | 32 | Load data |
| res_valid_o | output | 1 | Results valid, one cycle after issue |
| res_o | output | 128 | Four 32-bit lane results |
| acc_o | output | 160 | Four 40-bit accumulators |

## Verification
A wrong element in the file stays hidden until some lane gathers it. The bench therefore reads the whole file back in groups of four after loading it. It also reads back every location that a scatter, a collision or an idle cycle might have touched, one cycle after the stimulus. A corrupted accumulator shows on `acc_o` at the next edge. A wrong sum also spreads into every later filter result, so checks on each step detect it on the first faulty cycle. A broken lane priority or read-before-write order changes `res_o` on the very next gather of the affected index.

// File: rtl/vgm_pkg.sv
package vgm_pkg;
  typedef enum logic [1:0] {
    OP_MOV  = 2'b00,
    OP_ADD  = 2'b01,
    OP_MAC  = 2'b10,
    OP_IDLE = 2'b11
  } vgm_op_e;
endpackage

// File: rtl/vgm_elem_file.sv
module vgm_elem_file #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*IW-1:0] rd_a_idx_i,
  input  logic [LANES*IW-1:0] rd_b_idx_i,
  output logic [LANES*DW-1:0] rd_a_o,
  output logic [LANES*DW-1:0] rd_b_o,
  input  logic                wr_en_i,
  input  logic [LANES*IW-1:0] wr_idx_i,
  input  logic [LANES*DW-1:0] wr_data_i,
  input  logic                ld_en_i,
  input  logic [IW-1:0]       ld_idx_i,
  input  logic [DW-1:0]       ld_data_i
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_gather
    assign rd_a_o[l*DW +: DW] = mem_q[rd_a_idx_i[l*IW +: IW]];
    assign rd_b_o[l*DW +: DW] = mem_q[rd_b_idx_i[l*IW +: IW]];
  end

  // later assignments win: load first, then lanes in ascending order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      if (ld_en_i) mem_q[ld_idx_i] <= ld_data_i;
      if (wr_en_i) begin
        for (int l = 0; l < LANES; l++)
          mem_q[wr_idx_i[l*IW +: IW]] <= wr_data_i[l*DW +: DW];
      end
    end
  end

  // checker state: last write of the top lane
  logic          top_vld_q;
  logic [IW-1:0] top_idx_q;
  logic [DW-1:0] top_dat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_vld_q <= 1'b0;
      top_idx_q <= '0;
      top_dat_q <= '0;
    end else begin
      top_vld_q <= wr_en_i;
      top_idx_q <= wr_idx_i[(LANES-1)*IW +: IW];
      top_dat_q <= wr_data_i[(LANES-1)*DW +: DW];
    end
  end

  p_top_lane_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld_q |-> mem_q[top_idx_q] == top_dat_q);

  p_load_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !wr_en_i) |=> mem_q[$past(ld_idx_i)] == $past(ld_data_i));
endmodule

// File: rtl/vgm_lane.sv
module vgm_lane
  import vgm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 40,
  parameter int MW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  vgm_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          clr_i,
  output logic [DW-1:0] res_o,
  output logic [AW-1:0] acc_o
);
  localparam int PW = 2 * MW;

  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext, acc_base, acc_nxt, acc_q;
  logic                 mac;

  assign prod     = $signed(a_i[MW-1:0]) * $signed(b_i[MW-1:0]);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign mac      = en_i && (op_i == OP_MAC);
  assign acc_base = clr_i ? '0 : acc_q;
  assign acc_nxt  = acc_base + prod_ext;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_MAC:  res_o = acc_nxt[DW-1:0];
      default: res_o = a_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (mac)   acc_q <= acc_nxt;
    else if (clr_i) acc_q <= '0;
  end

  assign acc_o = acc_q;

  p_acc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !mac) |=> acc_q == '0);

  p_acc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !mac) |=> $stable(acc_q));
endmodule

// File: rtl/vgather_mac_dp.sv
module vgather_mac_dp
  import vgm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int AW    = 40,
  parameter int MW    = 16,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_i,
  input  logic [1:0]          op_i,
  input  logic [LANES*IW-1:0] src_a_idx_i,
  input  logic [LANES*IW-1:0] src_b_idx_i,
  input  logic [LANES*IW-1:0] dst_idx_i,
  input  logic                acc_clr_i,
  input  logic                ld_en_i,
  input  logic [IW-1:0]       ld_idx_i,
  input  logic [DW-1:0]       ld_data_i,
  output logic                res_valid_o,
  output logic [LANES*DW-1:0] res_o,
  output logic [LANES*AW-1:0] acc_o
);
  vgm_op_e             op;
  logic                do_op;
  logic [LANES*DW-1:0] opnd_a, opnd_b, lane_res;

  assign op    = vgm_op_e'(op_i);
  assign do_op = issue_i && (op != OP_IDLE);

  vgm_elem_file #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) u_file (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (src_a_idx_i),
    .rd_b_idx_i (src_b_idx_i),
    .rd_a_o     (opnd_a),
    .rd_b_o     (opnd_b),
    .wr_en_i    (do_op),
    .wr_idx_i   (dst_idx_i),
    .wr_data_i  (lane_res),
    .ld_en_i    (ld_en_i),
    .ld_idx_i   (ld_idx_i),
    .ld_data_i  (ld_data_i)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vgm_lane #(.DW(DW), .AW(AW), .MW(MW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (do_op),
      .op_i   (op),
      .a_i    (opnd_a[l*DW +: DW]),
      .b_i    (opnd_b[l*DW +: DW]),
      .clr_i  (acc_clr_i),
      .res_o  (lane_res[l*DW +: DW]),
      .acc_o  (acc_o[l*AW +: AW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= do_op;
      if (do_op) res_o <= lane_res;
    end
  end

  p_valid_after_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_op |=> res_valid_o);

  p_no_valid_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_op |=> !res_valid_o);

  p_broadcast_gather_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_idx_i[0 +: IW] == src_a_idx_i[IW +: IW]) |->
      opnd_a[0 +: DW] == opnd_a[DW +: DW]);
endmodule

// File: tb/vgather_mac_dp_bench.sv
module vgather_mac_dp_bench;
  localparam int L = 4, DW = 32, AW = 40, D = 128, IW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue = 1'b0;
  logic [1:0]    op = 2'b11;
  logic [L*IW-1:0] a_idx = '0, b_idx = '0, d_idx = '0;
  logic          clr = 1'b0;
  logic          ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [DW-1:0] ld_data = '0;
  logic          res_valid;
  logic [L*DW-1:0] res;
  logic [L*AW-1:0] acc;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mdl_mem [D];
  logic [AW-1:0] mdl_acc [L];
  logic [DW-1:0] mdl_res [L];

  always #5 clk = ~clk;

  vgather_mac_dp u_vgather_mac_dp (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op),
    .src_a_idx_i(a_idx), .src_b_idx_i(b_idx), .dst_idx_i(d_idx),
    .acc_clr_i(clr), .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .res_valid_o(res_valid), .res_o(res), .acc_o(acc)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L*IW-1:0] pk(input int i0, input int i1, input int i2, input int i3);
    return {IW'(i3), IW'(i2), IW'(i1), IW'(i0)};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic load(input int idx, input logic [DW-1:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    mdl_mem[idx] = val;
  endtask

  // drive one operation (optionally with a same-cycle load), check one cycle later
  task automatic run_op(input logic [1:0] o, input logic [L*IW-1:0] ai, input logic [L*IW-1:0] bi,
                        input logic [L*IW-1:0] di, input logic c, input logic le,
                        input int li, input logic [DW-1:0] ldv, input string req);
    logic [DW-1:0] av, bv;
    logic signed [31:0] p;
    logic act = (o != 2'b11);
    @(negedge clk);
    issue = 1'b1; op = o; a_idx = ai; b_idx = bi; d_idx = di; clr = c;
    ld_en = le; ld_idx = IW'(li); ld_data = ldv;
    for (int l = 0; l < L; l++) begin
      av = mdl_mem[ai[l*IW +: IW]];
      bv = mdl_mem[bi[l*IW +: IW]];
      p  = $signed(av[15:0]) * $signed(bv[15:0]);
      if (o == 2'b10) begin
        mdl_acc[l] = (c ? '0 : mdl_acc[l]) + {{8{p[31]}}, p};
        mdl_res[l] = mdl_acc[l][DW-1:0];
      end else begin
        if (c) mdl_acc[l] = '0;
        if (o == 2'b01) mdl_res[l] = av + bv;
        else if (o == 2'b00) mdl_res[l] = av;
      end
    end
    if (le) mdl_mem[li] = ldv;
    if (act) for (int l = 0; l < L; l++) mdl_mem[di[l*IW +: IW]] = mdl_res[l];
    @(negedge clk);
    issue = 1'b0; op = 2'b11; clr = 1'b0; ld_en = 1'b0;
    chk(res_valid == act, {req, " valid"}, 64'(res_valid), 64'(act));
    for (int l = 0; l < L; l++) begin
      if (act) chk(res[l*DW +: DW] == mdl_res[l], {req, " res"}, 64'(res[l*DW +: DW]), 64'(mdl_res[l]));
      chk(acc[l*AW +: AW] == mdl_acc[l], {req, " acc"}, 64'(acc[l*AW +: AW]), 64'(mdl_acc[l]));
    end
  endtask

  task automatic read4(input int i0, input int i1, input int i2, input int i3, input string req);
    run_op(2'b00, pk(i0,i1,i2,i3), pk(0,0,0,0), pk(i0,i1,i2,i3), 1'b0, 1'b0, 0, '0, req);
  endtask

  initial begin
    for (int e = 0; e < D; e++) mdl_mem[e] = '0;
    for (int l = 0; l < L; l++) begin mdl_acc[l] = '0; mdl_res[l] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports and in the file
    chk(res_valid == 1'b0, "R1 valid", 64'(res_valid), 0);
    chk(res == '0, "R1 res", 64'(res[63:0]), 0);
    chk(acc == '0, "R1 acc", 64'(acc[63:0]), 0);
    rst_n = 1'b1;
    read4(0, 45, 90, 127, "R1 file");

    // R2: fill the whole file through the load port, read it all back (R3)
    for (int e = 0; e < D; e++) load(e, 32'(e) * 32'h9E37_79B9 + 32'h1234);
    for (int g = 0; g < D / 4; g++) read4(4*g, 4*g+1, 4*g+2, 4*g+3, "R2 R3 readback");

    // R4 with R7 patterns: broadcast, stride 2, reversed pairs, back to back
    for (int b = 0; b < 40; b++) begin
      run_op(2'b01, pk(b,b+2,b+4,b+6), pk(b+6,b+7,b+4,b+5), pk(100+b%8,108+b%8,116+b%8,124),
             1'b0, 1'b0, 0, '0, "R4 R7 stride add");
      run_op(2'b01, pk(b,b,b,b), pk(b+1,b+3,b+5,b+7), pk(64+b%4,68,72,76),
             1'b0, 1'b0, 0, '0, "R7 broadcast add");
    end
    load(50, 32'hFFFF_FFFF); load(51, 32'h0000_0002);
    run_op(2'b01, pk(50,50,51,50), pk(51,50,51,50), pk(52,53,54,55), 1'b0, 1'b0, 0, '0, "R4 wrap");

    // R5 R6: four-lane FIR with broadcast coefficient, clear on first tap
    load(90, 32'h0001_FFFD);
    for (int t = 0; t < 8; t++)
      run_op(2'b10, pk(t,t+1,t+2,t+3), pk(90,90,90,90), pk(120,121,122,123),
             (t == 0), 1'b0, 0, '0, "R5 R6 fir tap");
    read4(120, 121, 122, 123, "R5 scatter");

    // R6: clear without multiply-accumulate
    run_op(2'b11, pk(0,0,0,0), pk(0,0,0,0), pk(30,31,32,33), 1'b1, 1'b0, 0, '0, "R6 clear");

    // R5: 40-bit wrap, 520 products of (-32768)^2
    load(126, 32'h0000_8000);
    for (int k = 0; k < 520; k++)
      run_op(2'b10, pk(126,126,126,126), pk(126,126,126,126), pk(125,125,125,125),
             (k == 0), 1'b0, 0, '0, "R5 acc wrap");
    chk(acc[AW-1:0] == 40'h82_0000_0000, "R5 wrap value", 64'(acc[AW-1:0]), 64'h82_0000_0000);

    // R8: destination collision, top lane wins; scatter beats load
    run_op(2'b00, pk(10,11,12,13), pk(0,0,0,0), pk(5,5,5,5), 1'b0, 1'b0, 0, '0, "R8 collision");
    read4(5, 5, 5, 5, "R8 collision readback");
    chk(res[DW-1:0] == mdl_mem[13], "R8 lane3 value", 64'(res[DW-1:0]), 64'(mdl_mem[13]));
    run_op(2'b00, pk(20,21,22,23), pk(0,0,0,0), pk(6,7,9,8), 1'b0, 1'b1, 9, 32'hDEAD_BEEF, "R8 load clash");
    read4(9, 9, 9, 9, "R8 load clash readback");

    // R9: read old value in write cycle, new value the next cycle
    run_op(2'b01, pk(40,41,42,43), pk(40,40,40,40), pk(40,41,42,43), 1'b0, 1'b0, 0, '0, "R9 same cycle");
    run_op(2'b00, pk(40,41,42,43), pk(0,0,0,0), pk(44,45,46,47), 1'b0, 1'b0, 0, '0, "R9 next cycle");

    // R10: idle op and no issue leave file and accumulators alone
    run_op(2'b10, pk(1,2,3,4), pk(5,6,7,8), pk(0,0,0,0), 1'b1, 1'b0, 0, '0, "R10 setup");
    run_op(2'b11, pk(1,2,3,4), pk(5,6,7,8), pk(30,31,32,33), 1'b0, 1'b0, 0, '0, "R10 idle op");
    @(negedge clk);
    op = 2'b01; d_idx = pk(34,35,36,37); a_idx = pk(1,2,3,4);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 no issue valid", 64'(res_valid), 0);
    op = 2'b11;
    read4(30, 31, 32, 33, "R10 idle readback");
    read4(34, 35, 36, 37, "R10 no issue readback");

    summary();
  end
endmodule